// File: doc/BRIEF.md
# Packet Statistics Counter Bank with Ordered Read-Clear

This block counts four kinds of traffic events on a network PHY: transmitted packets, transmit error packets, received packets and receive error packets. Each event arrives as a single-cycle pulse on its own input. Software reads the totals through a plain read port made of an address, a strobe and a data bus. Each strobe is accepted in the cycle it is asserted. The port has no back-pressure and no valid/ready handshake, so software may issue a read every cycle.

The six readable registers form two groups of three: a transmit group and a receive group. The first read of a group takes a snapshot, and the group returns that snapshot until its last register is read. The group is cleared only when its three registers are read in strictly ascending order with no other read of that group in between. A clear subtracts the snapshot from the live counters. Events that arrive while software is reading therefore carry over into the next interval and are not lost.

Top module: `pkt_stat_bank`

## Requirements
- R1: After reset, all six registers read zero.
- R2: Each event pulse adds one to its own counter. The address map is: 0x12B holds TX packets bits [15:0], 0x12C holds TX packets bits [PKT_W-1:16] zero-extended, 0x12D holds TX errors, 0x12E holds RX packets bits [15:0], 0x12F holds RX packets bits [PKT_W-1:16], and 0x130 holds RX errors, zero-extended to 16 bits.
- R3: A read of a group that is not frozen captures a snapshot of that group. Later reads of the group return the snapshot, not the live count, until the freeze is released.
- R4: Reading 0x12B, 0x12C, 0x12D (TX) or 0x12E, 0x12F, 0x130 (RX) in that order, with no other read of that group in between, clears the group. Events counted during the sequence remain in the counters.
- R5: Any other order of reads within a group, such as first, second, first, second, third, leaves the counts uncleared. A read of the group's third register always releases the freeze.
- R6: The two groups are tracked independently. Reads of one group, including a broken sequence, neither break nor complete the other group's sequence.
- R7: Error counters saturate at 2^ERR_W-1 (0xFFFF by default). A clear subtracts from the saturated value.
- R8: Packet counters wrap modulo 2^PKT_W (2^32 by default).
- R9: rd_data carries the addressed value in the cycle after rd_en is high, and is zero in a cycle that follows a cycle without rd_en.
- R10: A read outside 0x12B–0x130 returns zero and changes neither group's sequence state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_pkt_evt | input | 1 | One transmitted packet |
| tx_err_evt | input | 1 | One transmit error packet |
| rx_pkt_evt | input | 1 | One received packet |
| rx_err_evt | input | 1 | One receive error packet |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | REG_W | Read data, registered |

## Verification
An event pulse that is high at a rising edge is counted at that edge. A read strobe captures its data at the same edge, so rd_data is due one edge later. The bench changes every input on the falling edge and samples rd_data on the next falling edge, halfway between the capturing edge and the following one. A snapshot or a clear therefore takes effect before the next read, which starts at least one full cycle later. Expected totals come from the counts of pulses issued, minus the snapshot whenever an ordered sequence completes.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int NUM_GRP      = 2;
  localparam int REGS_PER_GRP = 3;

  // Position of a register inside its group; the order is the read order.
  typedef enum logic [1:0] {
    SEL_PKT_LO = 2'd0,
    SEL_PKT_HI = 2'd1,
    SEL_ERR    = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/stat_seq.sv
module stat_seq
  import stat_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rd_hit,
  input  reg_sel_e rd_idx,
  output logic     frozen,
  output logic     snap_take,
  output logic     clr_fire
);
  logic     frz_q;
  logic     brk_q;
  reg_sel_e exp_q;

  assign frozen = frz_q;

  always_comb begin
    snap_take = rd_hit && !frz_q && (rd_idx != SEL_ERR);
    clr_fire  = rd_hit && frz_q && (rd_idx == SEL_ERR) &&
                !brk_q && (exp_q == SEL_ERR);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frz_q <= 1'b0;
      brk_q <= 1'b0;
      exp_q <= SEL_PKT_LO;
    end else if (rd_hit) begin
      if (!frz_q) begin
        // first access of the group; a third-register read on its own
        // never holds the group
        frz_q <= (rd_idx != SEL_ERR);
        brk_q <= (rd_idx != SEL_PKT_LO);
        exp_q <= reg_sel_e'(rd_idx + 2'd1);
      end else if (rd_idx == SEL_ERR) begin
        frz_q <= 1'b0;
        brk_q <= 1'b0;
        exp_q <= SEL_PKT_LO;
      end else begin
        brk_q <= brk_q | (rd_idx != exp_q);
        exp_q <= reg_sel_e'(rd_idx + 2'd1);
      end
    end
  end
endmodule

// File: rtl/stat_cnt.sv
module stat_cnt #(
  parameter int W        = 16,
  parameter bit SATURATE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt,
  input  logic         snap_en,
  input  logic         clr,
  output logic [W-1:0] live,
  output logic [W-1:0] snap
);
  logic [W-1:0] live_q, snap_q, base, nxt;

  assign base = clr ? (live_q - snap_q) : live_q;

  generate
    if (SATURATE) begin : g_sat
      assign nxt = (evt && (base != '1)) ? base + W'(1) : base;
    end else begin : g_wrap
      assign nxt = base + W'(evt);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
      snap_q <= '0;
    end else begin
      live_q <= nxt;
      if (snap_en) snap_q <= live_q;
    end
  end

  assign live = live_q;
  assign snap = snap_q;
endmodule

// File: rtl/stat_group.sv
module stat_group
  import stat_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int PKT_W = 32,
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_evt,
  input  logic             err_evt,
  input  logic             rd_hit,
  input  reg_sel_e         rd_idx,
  output logic [REG_W-1:0] rd_val,
  output logic             frozen,
  output logic             clr,
  output logic [ERR_W-1:0] err_live,
  output logic [PKT_W-1:0] pkt_snap
);
  localparam int EXT_W = 2 * REG_W;

  logic             snap_take;
  logic [PKT_W-1:0] pkt_live, pkt_sel;
  logic [ERR_W-1:0] err_snap, err_sel;
  logic [EXT_W-1:0] pkt_ext;

  stat_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_hit    (rd_hit),
    .rd_idx    (rd_idx),
    .frozen    (frozen),
    .snap_take (snap_take),
    .clr_fire  (clr)
  );

  stat_cnt #(.W(PKT_W), .SATURATE(1'b0)) u_pkt (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (pkt_evt),
    .snap_en (snap_take),
    .clr     (clr),
    .live    (pkt_live),
    .snap    (pkt_snap)
  );

  stat_cnt #(.W(ERR_W), .SATURATE(1'b1)) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (err_evt),
    .snap_en (snap_take),
    .clr     (clr),
    .live    (err_live),
    .snap    (err_snap)
  );

  assign pkt_sel = frozen ? pkt_snap : pkt_live;
  assign err_sel = frozen ? err_snap : err_live;
  assign pkt_ext = EXT_W'(pkt_sel);

  always_comb begin
    case (rd_idx)
      SEL_PKT_LO: rd_val = pkt_ext[REG_W-1:0];
      SEL_PKT_HI: rd_val = pkt_ext[EXT_W-1:REG_W];
      SEL_ERR:    rd_val = REG_W'(err_sel);
      default:    rd_val = '0;
    endcase
  end
endmodule

// File: rtl/pkt_stat_bank.sv
module pkt_stat_bank
  import stat_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(12'h12B),
  parameter int                REG_W     = 16,
  parameter int                PKT_W     = 32,
  parameter int                ERR_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_pkt_evt,
  input  logic              tx_err_evt,
  input  logic              rx_pkt_evt,
  input  logic              rx_err_evt,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data
);
  localparam int NREG = NUM_GRP * REGS_PER_GRP;

  logic [ADDR_W-1:0] off;
  logic              in_rng;
  logic              grp_sel;
  reg_sel_e          idx;

  assign off     = rd_addr - BASE_ADDR;
  assign in_rng  = (rd_addr >= BASE_ADDR) && (off < ADDR_W'(NREG));
  assign grp_sel = (off >= ADDR_W'(REGS_PER_GRP));
  assign idx     = reg_sel_e'(2'(grp_sel ? off - ADDR_W'(REGS_PER_GRP) : off));

  logic [NUM_GRP-1:0]            pkt_evt, err_evt, hit;
  logic [NUM_GRP-1:0]            grp_frozen, grp_clr;
  logic [NUM_GRP-1:0][REG_W-1:0] grp_val;
  logic [NUM_GRP-1:0][ERR_W-1:0] grp_err_live;
  logic [NUM_GRP-1:0][PKT_W-1:0] grp_snap_pkt;

  assign pkt_evt = {rx_pkt_evt, tx_pkt_evt};
  assign err_evt = {rx_err_evt, tx_err_evt};

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      assign hit[g] = rd_en && in_rng && (grp_sel == 1'(g));

      stat_group #(.REG_W(REG_W), .PKT_W(PKT_W), .ERR_W(ERR_W)) u_grp (
        .clk      (clk),
        .rst_n    (rst_n),
        .pkt_evt  (pkt_evt[g]),
        .err_evt  (err_evt[g]),
        .rd_hit   (hit[g]),
        .rd_idx   (idx),
        .rd_val   (grp_val[g]),
        .frozen   (grp_frozen[g]),
        .clr      (grp_clr[g]),
        .err_live (grp_err_live[g]),
        .pkt_snap (grp_snap_pkt[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= (rd_en && in_rng) ? grp_val[grp_sel] : '0;
  end
endmodule

// File: rtl/stat_chk.sv
module stat_chk #(
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(12'h12B),
  parameter int                REG_W     = 16,
  parameter int                PKT_W     = 32,
  parameter int                ERR_W     = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rd_en,
  input logic [ADDR_W-1:0]     rd_addr,
  input logic [REG_W-1:0]      rd_data,
  input logic [1:0]            grp_frozen,
  input logic [1:0]            grp_clr,
  input logic [1:0][ERR_W-1:0] grp_err_live,
  input logic [1:0][PKT_W-1:0] grp_snap_pkt
);
  logic in_map;
  assign in_map = (rd_addr >= BASE_ADDR) && (rd_addr < BASE_ADDR + ADDR_W'(6));

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rd_data == '0));

  p_outside_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !in_map) |=> (rd_data == '0));

  generate
    for (genvar g = 0; g < 2; g++) begin : g_chk
      localparam logic [ADDR_W-1:0] FIRST = BASE_ADDR + ADDR_W'(3 * g);
      localparam logic [ADDR_W-1:0] THIRD = BASE_ADDR + ADDR_W'(3 * g + 2);

      p_first_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == FIRST && !grp_frozen[g]) |=> grp_frozen[g]);

      p_snap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_frozen[g] && !(rd_en && rd_addr == THIRD))
          |=> (grp_frozen[g] && $stable(grp_snap_pkt[g])));

      p_third_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == THIRD) |=> !grp_frozen[g]);

      p_clear_when_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        grp_clr[g] |-> grp_frozen[g]);

      p_err_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_err_live[g] == '1 && !grp_clr[g]) |=> (grp_err_live[g] == '1));
    end
  endgenerate
endmodule

bind pkt_stat_bank stat_chk #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .REG_W(REG_W),
  .PKT_W(PKT_W), .ERR_W(ERR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_en        (rd_en),
  .rd_addr      (rd_addr),
  .rd_data      (rd_data),
  .grp_frozen   (grp_frozen),
  .grp_clr      (grp_clr),
  .grp_err_live (grp_err_live),
  .grp_snap_pkt (grp_snap_pkt)
);

// File: tb/sim_pkt_stat_bank.sv
`timescale 1ns/1ps
module sim_pkt_stat_bank;
  localparam int ADDR_W = 12;
  localparam int PKT_W  = 17;
  localparam int ERR_W  = 4;

  localparam logic [11:0] A_TPL = 12'h12B, A_TPH = 12'h12C, A_TER = 12'h12D;
  localparam logic [11:0] A_RPL = 12'h12E, A_RPH = 12'h12F, A_RER = 12'h130;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  evt = '0;   // 0 tx pkt, 1 tx err, 2 rx pkt, 3 rx err
  logic        rd_en = 1'b0;
  logic [11:0] rd_addr = '0;
  logic [15:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pkt_stat_bank #(.ADDR_W(ADDR_W), .PKT_W(PKT_W), .ERR_W(ERR_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .tx_pkt_evt(evt[0]), .tx_err_evt(evt[1]),
    .rx_pkt_evt(evt[2]), .rx_err_evt(evt[3]),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic rdx(input logic [11:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0;
    check(tag, rd_data, exp);
  endtask

  task automatic burst(input int sel, input int n);
    @(negedge clk); evt[sel] = 1'b1;
    repeat (n) @(negedge clk);
    evt[sel] = 1'b0;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rdx(A_TPL, 0, "R1 tx lo"); rdx(A_TPH, 0, "R1 tx hi"); rdx(A_TER, 0, "R1 tx err");
    rdx(A_RPL, 0, "R1 rx lo"); rdx(A_RPH, 0, "R1 rx hi"); rdx(A_RER, 0, "R1 rx err");
    @(negedge clk); check("R9 idle zero", rd_data, 0);

    // R2 counting and map, R4 clear
    burst(0, 5); burst(1, 3); burst(2, 7); burst(3, 2);
    rdx(A_TPL, 5, "R2 tx pkt"); rdx(A_TPH, 0, "R2 tx hi"); rdx(A_TER, 3, "R2 tx err");
    @(negedge clk); check("R9 idle after read", rd_data, 0);
    rdx(A_RPL, 7, "R2 rx pkt"); rdx(A_RPH, 0, "R2 rx hi"); rdx(A_RER, 2, "R2 rx err");
    rdx(A_TPL, 0, "R4 tx cleared"); rdx(A_TPH, 0, "R4 tx hi"); rdx(A_TER, 0, "R4 tx err cleared");
    rdx(A_RPL, 0, "R4 rx cleared"); rdx(A_RPH, 0, "R4 rx hi"); rdx(A_RER, 0, "R4 rx err cleared");

    // R3 snapshot held, R4 events during the sequence carried over
    burst(1, 3);
    rdx(A_TPL, 0, "R3 lo");
    burst(1, 2);
    rdx(A_TPH, 0, "R3 hi");
    rdx(A_TER, 3, "R3 frozen err");
    rdx(A_TPL, 0, "R4 lo"); rdx(A_TPH, 0, "R4 hi"); rdx(A_TER, 2, "R4 carried err");
    rdx(A_TPL, 0, "R4 lo2"); rdx(A_TPH, 0, "R4 hi2"); rdx(A_TER, 0, "R4 err2");

    // R5 broken order 1,2,1,2,3 does not clear
    burst(0, 6);
    rdx(A_TPL, 6, "R5 a"); rdx(A_TPH, 0, "R5 b"); rdx(A_TPL, 6, "R5 c");
    rdx(A_TPH, 0, "R5 d"); rdx(A_TER, 0, "R5 e");
    burst(0, 1);
    rdx(A_TPL, 7, "R5 not cleared"); rdx(A_TPH, 0, "R5 f"); rdx(A_TER, 0, "R5 g");
    rdx(A_TPL, 0, "R5 released then cleared"); rdx(A_TPH, 0, "R5 h"); rdx(A_TER, 0, "R5 i");

    // R10 out-of-range reads return zero, sequence kept
    burst(2, 9);
    rdx(A_RPL, 9, "R10 first");
    rdx(12'h12A, 0, "R10 below"); rdx(12'h131, 0, "R10 above");
    rdx(A_RPH, 0, "R10 hi"); rdx(A_RER, 0, "R10 err");
    rdx(A_RPL, 0, "R10 cleared"); rdx(A_RPH, 0, "R10 hi2"); rdx(A_RER, 0, "R10 err2");

    // R6 interleaved groups both complete
    burst(0, 3); burst(2, 4);
    rdx(A_TPL, 3, "R6 tx"); rdx(A_RPL, 4, "R6 rx"); rdx(A_TPH, 0, "R6 a");
    rdx(A_RPH, 0, "R6 b"); rdx(A_TER, 0, "R6 c"); rdx(A_RER, 0, "R6 d");
    rdx(A_TPL, 0, "R6 tx cleared"); rdx(A_TPH, 0, "R6 e"); rdx(A_TER, 0, "R6 f");
    rdx(A_RPL, 0, "R6 rx cleared"); rdx(A_RPH, 0, "R6 g"); rdx(A_RER, 0, "R6 h");
    // R6 a broken RX sequence leaves TX clearing
    burst(0, 2); burst(2, 2);
    rdx(A_TPL, 2, "R6 tx2"); rdx(A_RPL, 2, "R6 rx2"); rdx(A_RPL, 2, "R6 rx2 again");
    rdx(A_TPH, 0, "R6 i"); rdx(A_RPH, 0, "R6 j"); rdx(A_TER, 0, "R6 k"); rdx(A_RER, 0, "R6 l");
    rdx(A_TPL, 0, "R6 tx clean"); rdx(A_TPH, 0, "R6 m"); rdx(A_TER, 0, "R6 n");
    rdx(A_RPL, 2, "R6 rx kept"); rdx(A_RPH, 0, "R6 o"); rdx(A_RER, 0, "R6 p");
    rdx(A_RPL, 0, "R6 rx clean"); rdx(A_RPH, 0, "R6 q"); rdx(A_RER, 0, "R6 r");

    // R7 saturation (max 15 with ERR_W=4)
    burst(1, 20);
    rdx(A_TPL, 0, "R7 a"); rdx(A_TPH, 0, "R7 b"); rdx(A_TER, 15, "R7 saturated");
    rdx(A_TPL, 0, "R7 c"); rdx(A_TPH, 0, "R7 d"); rdx(A_TER, 0, "R7 cleared");
    burst(3, 14);
    rdx(A_RPL, 0, "R7 e");
    burst(3, 5);
    rdx(A_RPH, 0, "R7 f"); rdx(A_RER, 14, "R7 frozen");
    rdx(A_RPL, 0, "R7 g"); rdx(A_RPH, 0, "R7 h"); rdx(A_RER, 1, "R7 sat minus snap");

    // R2 high half and R8 wrap (PKT_W=17)
    burst(0, 65538);
    rdx(A_TPL, 2, "R2 big lo"); rdx(A_TPH, 1, "R2 big hi");
    rdx(A_TPL, 2, "R8 break"); rdx(A_TPH, 1, "R8 hold"); rdx(A_TER, 0, "R8 release");
    burst(0, 65536);
    rdx(A_TPL, 2, "R8 wrapped lo"); rdx(A_TPH, 0, "R8 wrapped hi"); rdx(A_TER, 0, "R8 err");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule